// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block gives two independently clocked ports a side channel for single words that does not pass through the queues. Port A deposits a word into the first mailbox and port B picks it up. Port B deposits a word into the second mailbox and port A picks it up. Each mailbox has an active-low full flag. The flag falls in the writer's clock domain and rises again once the reader's release has crossed back into that domain. While the flag is low, the writer cannot replace the held word.

Each port has an enable, a write/read select and a mailbox select. On each port the output mux shows either the incoming mailbox or the queue output word that arrives on an input pin. The output drive is given as a separate enable signal, so no tristate is modelled. Port A reads when its write/read select is low. Port B reads when its select is high. A reset of the queue that goes with a mailbox empties that mailbox.

Top module: `mbox_pair`

## Requirements
- R1: A clkA rising edge with enA=1, wrRdA=1, mbSelA=1 and mbFull1N=1 stores dataInA in mailbox 1, and mbFull1N is 0 after that edge.
- R2: While mbFull1N is 0, port-A write attempts leave the mailbox 1 content unchanged.
- R3: A clkB edge with enB=1, wrRdB=1, mbSelB=1 releases a pending mailbox 1 word, and mbFull1N returns to 1 within three clkA edges. A read with mbSelB=0 does not release it.
- R4: Mailbox 2 mirrors R1 to R3. A clkB edge with enB=1, wrRdB=0, mbSelB=1 and mbFull2N=1 stores dataInB and drives mbFull2N to 0. Writes are blocked while mbFull2N is 0. A port-A read (enA=1, wrRdA=0, mbSelA=1) releases the word, and mbFull2N returns to 1 within three clkB edges.
- R5: dataOutA shows mailbox 2 when mbSelA=1 and fifo2Data when mbSelA=0. dataOutB shows mailbox 1 when mbSelB=1 and fifo1Data when mbSelB=0.
- R6: driveA equals the inverse of wrRdA, and driveB equals wrRdB. A port drives only when it is selected for read.
- R7: fifo1RstN low forces mbFull1N to 1 and clears mailbox 1 without waiting for a clock. fifo2RstN does the same for mbFull2N and mailbox 2. Neither reset touches the other mailbox.
- R8: Each accepted write is released exactly once. The word is visible at the reading port within three reader clock edges, and a read of an empty mailbox changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| fifo1RstN | input | 1 | Active-low reset of queue 1; clears mailbox 1 |
| fifo2RstN | input | 1 | Active-low reset of queue 2; clears mailbox 2 |
| enA | input | 1 | Port A access enable |
| wrRdA | input | 1 | Port A select, 1 = write, 0 = read |
| mbSelA | input | 1 | Port A mailbox select |
| dataInA | input | 36 | Port A write data |
| fifo2Data | input | 36 | Queue 2 output word shown at port A |
| dataOutA | output | 36 | Port A read data |
| driveA | output | 1 | Port A output drive enable |
| enB | input | 1 | Port B access enable |
| wrRdB | input | 1 | Port B select, 0 = write, 1 = read |
| mbSelB | input | 1 | Port B mailbox select |
| dataInB | input | 36 | Port B write data |
| fifo1Data | input | 36 | Queue 1 output word shown at port B |
| dataOutB | output | 36 | Port B read data |
| driveB | output | 1 | Port B output drive enable |
| mbFull1N | output | 1 | Mailbox 1 full flag, active low, clkA domain |
| mbFull2N | output | 1 | Mailbox 2 full flag, active low, clkB domain |

## Verification
The assertions assume the following about the inputs:
- Each port's controls are stable around its own rising edge.
- A reset is held low long enough to reach both domains before traffic resumes.
- The reading port only treats a word as new once enough of its own edges have passed since the write.

The bench keeps within these assumptions in four ways:
- It drives every input on the falling edge of the owning clock.
- The two clock periods are unrelated.
- It waits four reader edges before it samples or releases a word.
- It polls each flag for a bounded number of writer edges and does not expect a fixed arrival cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Load strobes from control to datapath, one per writer domain
  typedef struct packed {
    logic loadM1;  // clkA domain
    logic loadM2;  // clkB domain
  } mbox_strb_t;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clkA,
  input  logic       clkB,
  input  logic       fifo1RstN,
  input  logic       fifo2RstN,
  input  logic       enA,
  input  logic       wrRdA,
  input  logic       mbSelA,
  input  logic       enB,
  input  logic       wrRdB,
  input  logic       mbSelB,
  output mbox_strb_t strb,
  output logic       mbFull1N,
  output logic       mbFull2N
);
  logic wrTog1, rdTog1, wrTog2, rdTog2;
  logic rdTog1SyncA, wrTog1SyncB, wrTog2SyncA, rdTog2SyncB;
  logic relM1, relM2;

  mbox_sync #(.STAGES(SYNC_STAGES)) u_syncRd1A (.clk(clkA), .rstN(fifo1RstN), .d(rdTog1), .q(rdTog1SyncA));
  mbox_sync #(.STAGES(SYNC_STAGES)) u_syncWr1B (.clk(clkB), .rstN(fifo1RstN), .d(wrTog1), .q(wrTog1SyncB));
  mbox_sync #(.STAGES(SYNC_STAGES)) u_syncWr2A (.clk(clkA), .rstN(fifo2RstN), .d(wrTog2), .q(wrTog2SyncA));
  mbox_sync #(.STAGES(SYNC_STAGES)) u_syncRd2B (.clk(clkB), .rstN(fifo2RstN), .d(rdTog2), .q(rdTog2SyncB));

  // Flags: full while the writer toggle differs from the returned reader toggle
  assign mbFull1N = ~(wrTog1 ^ rdTog1SyncA);
  assign mbFull2N = ~(wrTog2 ^ rdTog2SyncB);

  // Port A: write selected by HIGH; Port B: write selected by LOW
  assign strb.loadM1 = enA &  wrRdA & mbSelA & mbFull1N;
  assign strb.loadM2 = enB & ~wrRdB & mbSelB & mbFull2N;

  // Release only when a word is seen pending in the reader domain
  assign relM1 = enB &  wrRdB & mbSelB & (wrTog1SyncB != rdTog1);
  assign relM2 = enA & ~wrRdA & mbSelA & (wrTog2SyncA != rdTog2);

  always_ff @(posedge clkA or negedge fifo1RstN) begin
    if (!fifo1RstN)       wrTog1 <= 1'b0;
    else if (strb.loadM1) wrTog1 <= ~wrTog1;
  end

  always_ff @(posedge clkB or negedge fifo1RstN) begin
    if (!fifo1RstN)  rdTog1 <= 1'b0;
    else if (relM1)  rdTog1 <= ~rdTog1;
  end

  always_ff @(posedge clkB or negedge fifo2RstN) begin
    if (!fifo2RstN)       wrTog2 <= 1'b0;
    else if (strb.loadM2) wrTog2 <= ~wrTog2;
  end

  always_ff @(posedge clkA or negedge fifo2RstN) begin
    if (!fifo2RstN)  rdTog2 <= 1'b0;
    else if (relM2)  rdTog2 <= ~rdTog2;
  end
endmodule

// File: rtl/mbox_data.sv
module mbox_data
  import mbox_pkg::*;
#(
  parameter int WIDTH = 36
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             fifo1RstN,
  input  logic             fifo2RstN,
  input  mbox_strb_t       strb,
  input  logic             wrRdA,
  input  logic             mbSelA,
  input  logic             wrRdB,
  input  logic             mbSelB,
  input  logic [WIDTH-1:0] dataInA,
  input  logic [WIDTH-1:0] dataInB,
  input  logic [WIDTH-1:0] fifo1Data,
  input  logic [WIDTH-1:0] fifo2Data,
  output logic [WIDTH-1:0] dataOutA,
  output logic [WIDTH-1:0] dataOutB,
  output logic             driveA,
  output logic             driveB,
  output logic [WIDTH-1:0] mail1Q,
  output logic [WIDTH-1:0] mail2Q
);
  always_ff @(posedge clkA or negedge fifo1RstN) begin
    if (!fifo1RstN)       mail1Q <= '0;
    else if (strb.loadM1) mail1Q <= dataInA;
  end

  always_ff @(posedge clkB or negedge fifo2RstN) begin
    if (!fifo2RstN)       mail2Q <= '0;
    else if (strb.loadM2) mail2Q <= dataInB;
  end

  assign dataOutA = mbSelA ? mail2Q : fifo2Data;
  assign dataOutB = mbSelB ? mail1Q : fifo1Data;
  assign driveA   = ~wrRdA;
  assign driveB   =  wrRdB;
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int WIDTH       = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clkA,
  input  logic             clkB,
  input  logic             fifo1RstN,
  input  logic             fifo2RstN,
  input  logic             enA,
  input  logic             wrRdA,
  input  logic             mbSelA,
  input  logic [WIDTH-1:0] dataInA,
  input  logic [WIDTH-1:0] fifo2Data,
  output logic [WIDTH-1:0] dataOutA,
  output logic             driveA,
  input  logic             enB,
  input  logic             wrRdB,
  input  logic             mbSelB,
  input  logic [WIDTH-1:0] dataInB,
  input  logic [WIDTH-1:0] fifo1Data,
  output logic [WIDTH-1:0] dataOutB,
  output logic             driveB,
  output logic             mbFull1N,
  output logic             mbFull2N
);
  mbox_strb_t       strb;
  logic [WIDTH-1:0] mail1Q, mail2Q;

  mbox_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkA(clkA), .clkB(clkB), .fifo1RstN(fifo1RstN), .fifo2RstN(fifo2RstN),
    .enA(enA), .wrRdA(wrRdA), .mbSelA(mbSelA),
    .enB(enB), .wrRdB(wrRdB), .mbSelB(mbSelB),
    .strb(strb), .mbFull1N(mbFull1N), .mbFull2N(mbFull2N)
  );

  mbox_data #(.WIDTH(WIDTH)) u_data (
    .clkA(clkA), .clkB(clkB), .fifo1RstN(fifo1RstN), .fifo2RstN(fifo2RstN),
    .strb(strb), .wrRdA(wrRdA), .mbSelA(mbSelA), .wrRdB(wrRdB), .mbSelB(mbSelB),
    .dataInA(dataInA), .dataInB(dataInB), .fifo1Data(fifo1Data), .fifo2Data(fifo2Data),
    .dataOutA(dataOutA), .dataOutB(dataOutB), .driveA(driveA), .driveB(driveB),
    .mail1Q(mail1Q), .mail2Q(mail2Q)
  );
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int WIDTH = 36
) (
  input logic             clkA,
  input logic             clkB,
  input logic             fifo1RstN,
  input logic             fifo2RstN,
  input logic             enA,
  input logic             wrRdA,
  input logic             mbSelA,
  input logic [WIDTH-1:0] dataInA,
  input logic             enB,
  input logic             wrRdB,
  input logic             mbSelB,
  input logic [WIDTH-1:0] dataInB,
  input logic             mbFull1N,
  input logic             mbFull2N,
  input logic [WIDTH-1:0] mail1Q,
  input logic [WIDTH-1:0] mail2Q
);
  // R1
  r1_store_chk: assert property (@(posedge clkA) disable iff (!fifo1RstN)
    (enA && wrRdA && mbSelA && mbFull1N) |=> (!mbFull1N && mail1Q == $past(dataInA)));

  // R2
  r2_no_overwrite_chk: assert property (@(posedge clkA) disable iff (!fifo1RstN)
    !mbFull1N |=> $stable(mail1Q));

  // R4
  r4_store_chk: assert property (@(posedge clkB) disable iff (!fifo2RstN)
    (enB && !wrRdB && mbSelB && mbFull2N) |=> (!mbFull2N && mail2Q == $past(dataInB)));

  // R4
  r4_no_overwrite_chk: assert property (@(posedge clkB) disable iff (!fifo2RstN)
    !mbFull2N |=> $stable(mail2Q));

  // R7
  r7_reset1_chk: assert property (@(posedge clkA)
    !fifo1RstN |-> (mbFull1N && mail1Q == '0));

  // R7
  r7_reset2_chk: assert property (@(posedge clkB)
    !fifo2RstN |-> (mbFull2N && mail2Q == '0));
endmodule

bind mbox_pair mbox_pair_chk #(.WIDTH(WIDTH)) u_chk (
  .clkA(clkA), .clkB(clkB), .fifo1RstN(fifo1RstN), .fifo2RstN(fifo2RstN),
  .enA(enA), .wrRdA(wrRdA), .mbSelA(mbSelA), .dataInA(dataInA),
  .enB(enB), .wrRdB(wrRdB), .mbSelB(mbSelB), .dataInB(dataInB),
  .mbFull1N(mbFull1N), .mbFull2N(mbFull2N), .mail1Q(mail1Q), .mail2Q(mail2Q)
);

// File: tb/mbox_pair_bench.sv
module mbox_pair_bench;
  localparam int W = 36;

  logic clkA = 1'b0, clkB = 1'b0;
  logic fifo1RstN, fifo2RstN;
  logic enA, wrRdA, mbSelA, enB, wrRdB, mbSelB;
  logic [W-1:0] dataInA, dataInB, fifo1Data, fifo2Data, dataOutA, dataOutB;
  logic driveA, driveB, mbFull1N, mbFull2N;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clkA = ~clkA;  // 50 MHz
  always #13 clkB = ~clkB;  // unrelated period

  mbox_pair u_mbox_pair (
    .clkA(clkA), .clkB(clkB), .fifo1RstN(fifo1RstN), .fifo2RstN(fifo2RstN),
    .enA(enA), .wrRdA(wrRdA), .mbSelA(mbSelA), .dataInA(dataInA),
    .fifo2Data(fifo2Data), .dataOutA(dataOutA), .driveA(driveA),
    .enB(enB), .wrRdB(wrRdB), .mbSelB(mbSelB), .dataInB(dataInB),
    .fifo1Data(fifo1Data), .dataOutB(dataOutB), .driveB(driveB),
    .mbFull1N(mbFull1N), .mbFull2N(mbFull2N)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseA(input logic wr, input logic sel, input logic [W-1:0] d);
    @(negedge clkA);
    enA = 1'b1; wrRdA = wr; mbSelA = sel; dataInA = d;
    @(negedge clkA);
    enA = 1'b0; wrRdA = 1'b0; mbSelA = 1'b1;
  endtask

  task automatic pulseB(input logic wr, input logic sel, input logic [W-1:0] d);
    @(negedge clkB);
    enB = 1'b1; wrRdB = wr; mbSelB = sel; dataInB = d;
    @(negedge clkB);
    enB = 1'b0; wrRdB = 1'b1; mbSelB = 1'b1;
  endtask

  // Wait up to three clkA edges for mbFull1N to rise
  task automatic waitFlag1(input string req);
    bit seen = 0;
    for (int i = 0; i < 3 && !seen; i++) begin
      @(posedge clkA); @(negedge clkA);
      if (mbFull1N) seen = 1;
    end
    chk(seen, req, {63'd0, mbFull1N}, 64'd1);
  endtask

  task automatic waitFlag2(input string req);
    bit seen = 0;
    for (int i = 0; i < 3 && !seen; i++) begin
      @(posedge clkB); @(negedge clkB);
      if (mbFull2N) seen = 1;
    end
    chk(seen, req, {63'd0, mbFull2N}, 64'd1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v, last1, last2;
    fifo1RstN = 1'b0; fifo2RstN = 1'b0;
    enA = 0; wrRdA = 0; mbSelA = 1; dataInA = '0; fifo2Data = '0;
    enB = 0; wrRdB = 1; mbSelB = 1; dataInB = '0; fifo1Data = '0;
    #1;
    // R7: reset state
    chk(mbFull1N === 1'b1 && mbFull2N === 1'b1, "R7 reset flags", {62'd0, mbFull1N, mbFull2N}, 64'd3);
    chk(dataOutA === '0 && dataOutB === '0, "R7 reset content", {28'd0, dataOutA}, 64'd0);
    repeat (4) @(negedge clkA);
    fifo1RstN = 1'b1; fifo2RstN = 1'b1;
    repeat (3) @(negedge clkB);

    // Mailbox 1 stream: R1, R2, R3, R8
    for (int k = 0; k < 12; k++) begin
      v = (W'(k) * 36'h0_0F0F_1357) ^ 36'hA_5A5A_5A5A;
      pulseA(1'b1, 1'b1, v);
      chk(mbFull1N == 1'b0, "R1 flag low after write", {63'd0, mbFull1N}, 64'd0);
      if (k % 3 == 0) begin
        pulseA(1'b1, 1'b1, ~v);
        chk(mbFull1N == 1'b0, "R2 flag stays low", {63'd0, mbFull1N}, 64'd0);
      end
      repeat (4) @(negedge clkB);
      chk(dataOutB === v, "R8 word visible at B (R2 not overwritten)", {28'd0, dataOutB}, {28'd0, v});
      if (k == 2) begin
        pulseB(1'b1, 1'b0, '0);
        repeat (5) @(negedge clkA);
        chk(mbFull1N == 1'b0, "R3 read with select low keeps flag", {63'd0, mbFull1N}, 64'd0);
      end
      pulseB(1'b1, 1'b1, '0);
      waitFlag1("R3 release within three clkA edges");
      if (k % 4 == 1) begin
        pulseB(1'b1, 1'b1, '0);
        repeat (5) @(negedge clkA);
        chk(mbFull1N == 1'b1, "R8 empty read no duplicate", {63'd0, mbFull1N}, 64'd1);
      end
      last1 = v;
    end

    // Mailbox 2 stream: R4, R8
    for (int k = 0; k < 12; k++) begin
      v = (W'(k) * 36'h0_1234_0F0F) ^ 36'h3_C3C3_C3C3;
      pulseB(1'b0, 1'b1, v);
      chk(mbFull2N == 1'b0, "R4 flag low after write", {63'd0, mbFull2N}, 64'd0);
      if (k % 3 == 1) begin
        pulseB(1'b0, 1'b1, ~v);
        chk(mbFull2N == 1'b0, "R4 flag stays low", {63'd0, mbFull2N}, 64'd0);
      end
      repeat (4) @(negedge clkA);
      mbSelA = 1'b1; wrRdA = 1'b0; #1;
      chk(dataOutA === v, "R4 word visible at A", {28'd0, dataOutA}, {28'd0, v});
      if (k == 3) begin
        pulseA(1'b0, 1'b0, '0);
        repeat (5) @(negedge clkB);
        chk(mbFull2N == 1'b0, "R4 read with select low keeps flag", {63'd0, mbFull2N}, 64'd0);
      end
      pulseA(1'b0, 1'b1, '0);
      waitFlag2("R4 release within three clkB edges");
      if (k % 4 == 2) begin
        pulseA(1'b0, 1'b1, '0);
        repeat (5) @(negedge clkB);
        chk(mbFull2N == 1'b1, "R8 empty read no duplicate", {63'd0, mbFull2N}, 64'd1);
      end
      last2 = v;
    end

    // Output mux and drive sweep: R5, R6
    @(negedge clkA);
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] fa, fb;
      fa = 36'h1_1111_0000 + W'(p);
      fb = 36'h2_2222_0000 + W'(p * 7);
      fifo2Data = fa; fifo1Data = fb;
      wrRdA = p[0]; mbSelA = p[1];
      wrRdB = p[0]; mbSelB = p[1];
      #1;
      chk(dataOutA === (p[1] ? last2 : fa), "R5 port A mux", {28'd0, dataOutA}, {28'd0, (p[1] ? last2 : fa)});
      chk(dataOutB === (p[1] ? last1 : fb), "R5 port B mux", {28'd0, dataOutB}, {28'd0, (p[1] ? last1 : fb)});
      chk(driveA === ~p[0] && driveB === p[0], "R6 drive enables", {62'd0, driveA, driveB}, {62'd0, ~p[0], p[0]});
    end
    wrRdA = 0; mbSelA = 1; wrRdB = 1; mbSelB = 1;

    // Resets: R7
    pulseA(1'b1, 1'b1, 36'h0_DEAD_BEEF);
    pulseB(1'b0, 1'b1, 36'h0_CAFE_F00D);
    @(negedge clkA);
    fifo1RstN = 1'b0; #1;
    chk(mbFull1N == 1'b1 && mbFull2N == 1'b0, "R7 queue 1 reset only", {62'd0, mbFull1N, mbFull2N}, 64'd2);
    chk(dataOutB === '0, "R7 mailbox 1 cleared", {28'd0, dataOutB}, 64'd0);
    repeat (4) @(negedge clkB);
    fifo1RstN = 1'b1;
    @(negedge clkB);
    fifo2RstN = 1'b0; #1;
    chk(mbFull2N == 1'b1 && mbFull1N == 1'b1, "R7 queue 2 reset", {62'd0, mbFull1N, mbFull2N}, 64'd3);
    chk(dataOutA === '0, "R7 mailbox 2 cleared", {28'd0, dataOutA}, 64'd0);
    repeat (4) @(negedge clkA);
    fifo2RstN = 1'b1;
    repeat (3) @(negedge clkB);

    // Mailbox 1 usable after reset: R1, R3
    pulseA(1'b1, 1'b1, 36'h5_0505_0505);
    chk(mbFull1N == 1'b0, "R1 write after reset", {63'd0, mbFull1N}, 64'd0);
    repeat (4) @(negedge clkB);
    pulseB(1'b1, 1'b1, '0);
    waitFlag1("R3 release after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule